// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Boot Mode

This block compares each external bus address against six programmable address windows and drives one active-low select line for the window that owns the access. Each window has a base register, a mask register and a control register. The mask register holds the don't-care bits for the compare and a valid bit that switches the window on. The control register holds a port size and an auto-acknowledge enable. Along with the select, the block outputs the port size and auto-acknowledge setting of the chosen window, so the bus cycle logic can use them.

Straight after reset no window is valid, and the block runs in a global boot mode. Select 0 fires for every access, whatever the address, so a boot memory can be reached before software has programmed any window. Its port size and auto-acknowledge come from three configuration pins, which are sampled while reset is held. Once software sets the valid bit of window 0, the block leaves global mode. Select 0 then decodes only its own window, and selects 1 to 5 become usable.

A synchronous write port loads the registers of each window. An access is marked by a one-cycle start strobe. The decode result is registered and appears in the cycle after the strobe.

Top module: `cs_decoder`

## Requirements
- R1: Reset clears the valid bit of every window, so the first access after reset is decoded in global mode.
- R2: While the valid bit of window 0 is clear, every access asserts select 0 alone, with `sel_hit` high and the latched boot port size and auto-acknowledge on the outputs.
- R3: The boot settings are sampled from `cfg_pins` while `rst_n` is low: `cfg_pins[2:1]` gives the port size code and `cfg_pins[0]` gives the auto-acknowledge enable. Changes on `cfg_pins` after reset is released have no effect.
- R4: A write with `wr_en` high loads register `wr_reg` of window `wr_sel`. Code 0 is the base register, taken from `wr_data[31:16]`. Code 1 is the mask register: the mask comes from `wr_data[31:16]` and the valid bit from `wr_data[0]`. Code 2 is the control register: the port size code comes from `wr_data[1:0]` and the auto-acknowledge enable from `wr_data[2]`. Code 3 writes nothing. A write takes effect for accesses that start in later cycles.
- R5: Once out of global mode, a valid window matches when `bus_addr[31:16]` equals its base in every bit where its mask bit is 0. Mask bits that are 1 are don't-care. A window whose valid bit is clear never matches.
- R6: While in global mode, selects 1 to 5 stay deasserted, even for a window that is valid and matches.
- R7: After window 0's valid bit is set, select 0 asserts only for addresses inside its own window.
- R8: When several windows match, only the lowest-numbered one asserts. At most one select is ever low.
- R9: `cs_n`, `sel_psize`, `sel_aack` and `sel_hit` are registered and reflect the access that started in the previous cycle. In a cycle after one with no start strobe, all selects are high, `sel_hit` is 0, `sel_psize` is 00 and `sel_aack` is 0.
- R10: An access that matches no window leaves all selects high, with `sel_hit` 0, `sel_psize` 00 and `sel_aack` 0.
- R11: Port size codes are 00 for 8-bit, 01 for 16-bit and 10 for 32-bit. The spare code 11 is output as 10 (32-bit).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; boot pins are sampled while it is low |
| cfg_pins | input | 3 | Boot configuration: [2:1] port size code, [0] auto-acknowledge enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Window number for the write |
| wr_reg | input | 2 | Register code: 0 base, 1 mask and valid, 2 control |
| wr_data | input | 32 | Write data |
| bus_start | input | 1 | One-cycle strobe marking the start of an access |
| bus_addr | input | 32 | Access address, valid with `bus_start` |
| cs_n | output | 6 | Active-low selects, one per window |
| sel_psize | output | 2 | Port size code of the selected window |
| sel_aack | output | 1 | Auto-acknowledge enable of the selected window |
| sel_hit | output | 1 | High when some select is asserted |

## Verification
The bench builds the block with its default parameters: six windows, a 32-bit address and a 16-bit compare field. With these, every select line, the boot pin latch and the 11 spare code can all be reached. The windows are programmed so that they overlap, so one address matches window 1 and window 2 together, and another matches window 4 and window 5. This exercises the priority order. One valid window is set up to match while window 0 is still not valid, which shows that global mode blocks it. One window is given a base that matches but is left not valid, which shows that the valid bit gates the compare.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CMP_W = 16;
  localparam int PS_W  = 2;

  localparam logic [PS_W-1:0] PS_8  = 2'b00;
  localparam logic [PS_W-1:0] PS_16 = 2'b01;
  localparam logic [PS_W-1:0] PS_32 = 2'b10;

  typedef struct packed {
    logic [PS_W-1:0] psize;
    logic            aack;
  } cs_attr_t;

  // compare the upper address field; mask bits set to 1 are don't-care
  function automatic logic field_match(input logic [CMP_W-1:0] addr_hi,
                                       input logic [CMP_W-1:0] base,
                                       input logic [CMP_W-1:0] mask);
    return ((addr_hi ^ base) & ~mask) == '0;
  endfunction

  // the spare code is treated as full width
  function automatic logic [PS_W-1:0] norm_psize(input logic [PS_W-1:0] code);
    return (code == 2'b11) ? PS_32 : code;
  endfunction
endpackage

// File: rtl/cs_boot_cfg.sv
module cs_boot_cfg
  import cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_pins,
  output cs_attr_t   boot_attr
);
  // follows the pins while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_attr.psize <= norm_psize(cfg_pins[2:1]);
      boot_attr.aack  <= cfg_pins[0];
    end
  end
endmodule

// File: rtl/cs_window.sv
module cs_window
  import cs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CMP_W-1:0]  addr_hi,
  output logic              valid,
  output logic              match,
  output cs_attr_t          attr
);
  localparam int HI_LSB = DATA_W - CMP_W;

  logic [CMP_W-1:0] base_q;
  logic [CMP_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      valid  <= 1'b0;
      attr   <= '0;
    end else if (wr_hit) begin
      case (wr_reg)
        2'd0: base_q <= wr_data[DATA_W-1:HI_LSB];
        2'd1: begin
          mask_q <= wr_data[DATA_W-1:HI_LSB];
          valid  <= wr_data[0];
        end
        2'd2: begin
          attr.psize <= norm_psize(wr_data[1:0]);
          attr.aack  <= wr_data[2];
        end
        default: ;
      endcase
    end
  end

  assign match = valid && field_match(addr_hi, base_q, mask_q);
endmodule

// File: rtl/cs_prio.sv
module cs_prio #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // lowest index wins: scan from the top so the lowest write lands last
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end
endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 32,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_pins,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_reg,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_CS-1:0] cs_n,
  output logic [PS_W-1:0]   sel_psize,
  output logic              sel_aack,
  output logic              sel_hit
);
  localparam int HI_LSB = ADDR_W - CMP_W;

  cs_attr_t          boot_attr;
  cs_attr_t          win_attr [NUM_CS];
  logic [NUM_CS-1:0] win_valid;
  logic [NUM_CS-1:0] win_hit;
  logic [NUM_CS-1:0] win_grant;
  logic              global_mode;
  logic [NUM_CS-1:0] next_sel;
  cs_attr_t          next_attr;

  cs_boot_cfg u_boot (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_pins (cfg_pins),
    .boot_attr(boot_attr)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    cs_window #(.DATA_W(ADDR_W)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_en && (wr_sel == SEL_W'(g))),
      .wr_reg (wr_reg),
      .wr_data(wr_data),
      .addr_hi(bus_addr[ADDR_W-1:HI_LSB]),
      .valid  (win_valid[g]),
      .match  (win_hit[g]),
      .attr   (win_attr[g])
    );
  end

  cs_prio #(.N(NUM_CS)) u_prio (
    .req  (win_hit),
    .grant(win_grant)
  );

  assign global_mode = !win_valid[0];

  always_comb begin
    next_attr = '0;
    if (global_mode) begin
      next_sel  = NUM_CS'(1);
      next_attr = boot_attr;
    end else begin
      next_sel = win_grant;
      for (int i = 0; i < NUM_CS; i++) begin
        if (win_grant[i]) next_attr = win_attr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_start) begin
      cs_n      <= '1;
      sel_psize <= '0;
      sel_aack  <= 1'b0;
      sel_hit   <= 1'b0;
    end else begin
      cs_n      <= ~next_sel;
      sel_psize <= next_attr.psize;
      sel_aack  <= next_attr.aack;
      sel_hit   <= |next_sel;
    end
  end
endmodule

// File: rtl/cs_decoder_chk.sv
module cs_decoder_chk
  import cs_pkg::*;
#(
  parameter int NUM_CS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_start,
  input logic              global_mode,
  input logic [NUM_CS-1:0] win_hit,
  input cs_attr_t          boot_attr,
  input logic [NUM_CS-1:0] cs_n,
  input logic [PS_W-1:0]   sel_psize,
  input logic              sel_aack,
  input logic              sel_hit
);
  // R8
  onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start |=> (&cs_n && !sel_hit && sel_psize == '0 && !sel_aack));

  // R2
  global_cs0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && global_mode) |=>
      (cs_n == ~NUM_CS'(1) && sel_hit &&
       sel_psize == $past(boot_attr.psize) && sel_aack == $past(boot_attr.aack)));

  // R6
  others_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    global_mode |=> (&cs_n[NUM_CS-1:1]));

  // R3
  boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(boot_attr));

  // R10
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !global_mode && win_hit == '0) |=>
      (&cs_n && !sel_hit && sel_psize == '0 && !sel_aack));

  // R8
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !global_mode && win_hit[0]) |=> !cs_n[0]);
endmodule

bind cs_decoder cs_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_start  (bus_start),
  .global_mode(global_mode),
  .win_hit    (win_hit),
  .boot_attr  (boot_attr),
  .cs_n       (cs_n),
  .sel_psize  (sel_psize),
  .sel_aack   (sel_aack),
  .sel_hit    (sel_hit)
);

// File: tb/cs_decoder_test.sv
module cs_decoder_test;
  localparam int NCS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_pins = 3'b101;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [1:0]  wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic        bus_start = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [5:0]  cs_n;
  logic [1:0]  sel_psize;
  logic        sel_aack;
  logic        sel_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cs_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_pins(cfg_pins),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_reg(wr_reg), .wr_data(wr_data),
    .bus_start(bus_start), .bus_addr(bus_addr),
    .cs_n(cs_n), .sel_psize(sel_psize), .sel_aack(sel_aack), .sel_hit(sel_hit)
  );

  // {address, cs_n, psize, aack, hit}
  typedef struct packed {
    logic [31:0] addr;
    logic [5:0]  csn;
    logic [1:0]  ps;
    logic        ack;
    logic        hit;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0003_0000, 6'b111110, 2'b00, 1'b0, 1'b1},  // R5 R7 window 0, masked low nibble
    '{32'h0010_0000, 6'b111111, 2'b00, 1'b0, 1'b0},  // R10 R7 no window
    '{32'h40F0_0000, 6'b111101, 2'b01, 1'b1, 1'b1},  // R5 window 1 only
    '{32'h4000_1234, 6'b111101, 2'b01, 1'b1, 1'b1},  // R8 windows 1 and 2, 1 wins
    '{32'h9000_0000, 6'b011111, 2'b10, 1'b1, 1'b1},  // R5 invalid window 3 ignored
    '{32'hA000_0000, 6'b101111, 2'b00, 1'b1, 1'b1},  // R8 windows 4 and 5, 4 wins
    '{32'hFFFF_FFFF, 6'b011111, 2'b10, 1'b1, 1'b1}   // R5 window 5 wide mask
  };

  task automatic check(input string req, input logic [5:0] csn, input logic [1:0] ps,
                       input logic ack, input logic hit);
    checks++;
    if (cs_n !== csn || sel_psize !== ps || sel_aack !== ack || sel_hit !== hit) begin
      errors++;
      $display("FAIL %s: got cs_n=%b ps=%b ack=%b hit=%b, expected cs_n=%b ps=%b ack=%b hit=%b",
               req, cs_n, sel_psize, sel_aack, sel_hit, csn, ps, ack, hit);
    end
  endtask

  task automatic wr(input int win, input int regc, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(win); wr_reg = 2'(regc); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // strobe at a falling edge, result registered at the next rising edge
  task automatic access(input logic [31:0] a);
    @(negedge clk);
    bus_start = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_start = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset idle", 6'b111111, 2'b00, 1'b0, 1'b0);
    cfg_pins = 3'b010;                       // R3 ignored after reset
    access(32'h1234_5678);
    check("R1 R2 R3 global boot access", 6'b111110, 2'b10, 1'b1, 1'b1);
    @(negedge clk);
    check("R9 idle after access", 6'b111111, 2'b00, 1'b0, 1'b0);

    // window 1 valid while window 0 is not
    wr(1, 0, 32'h4000_0000);
    wr(1, 1, 32'h00F0_0001);
    wr(1, 2, 32'h0000_0005);
    access(32'h40F0_0000);
    check("R6 window 1 blocked in global mode", 6'b111110, 2'b10, 1'b1, 1'b1);

    wr(2, 0, 32'h4000_0000);
    wr(2, 1, 32'h0000_0001);
    wr(2, 2, 32'h0000_0003);
    wr(3, 0, 32'h9000_0000);
    wr(3, 1, 32'h0000_0000);
    wr(3, 2, 32'h0000_0006);
    wr(4, 0, 32'hA000_0000);
    wr(4, 1, 32'h0000_0001);
    wr(4, 2, 32'h0000_0004);
    wr(5, 0, 32'h8000_0000);
    wr(5, 1, 32'h7FFF_0001);
    wr(5, 2, 32'h0000_0006);
    wr(0, 0, 32'h0000_0000);
    wr(0, 2, 32'h0000_0000);
    wr(0, 1, 32'h000F_0001);                 // R4 leaves global mode

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].addr);
      check($sformatf("vector %0d R5 R7 R8 R10", i), VECS[i].csn, VECS[i].ps,
            VECS[i].ack, VECS[i].hit);
    end

    // R11 spare code on window 2 once window 1 is off
    wr(1, 1, 32'h00F0_0000);
    access(32'h4000_0000);
    check("R11 spare code maps to 32-bit", 6'b111011, 2'b10, 1'b0, 1'b1);

    // R4 write of an unused code changes nothing
    wr(2, 3, 32'hFFFF_FFFF);
    access(32'h4000_0000);
    check("R4 code 3 writes nothing", 6'b111011, 2'b10, 1'b0, 1'b1);

    // R4 write and access in the same cycle: old value decodes
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'd2; wr_reg = 2'd1; wr_data = 32'h0;
    bus_start = 1'b1; bus_addr = 32'h4000_0000;
    @(negedge clk);
    wr_en = 1'b0; bus_start = 1'b0;
    check("R4 write lands after concurrent access", 6'b111011, 2'b10, 1'b0, 1'b1);
    access(32'h4000_0000);
    check("R4 window 2 now invalid", 6'b111111, 2'b00, 1'b0, 1'b0);

    // R1 R3 second reset with other pins
    @(negedge clk);
    rst_n = 1'b0; cfg_pins = 3'b010;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cfg_pins = 3'b111;
    access(32'hA000_0000);
    check("R1 R3 back to global mode with new pins", 6'b111110, 2'b01, 1'b0, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule